// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Dirty Tracking

The block is a small, fully associative translation buffer for a processor pipeline that uses 1 KB pages. Each lookup presents a 32-bit virtual address and a write flag. In the same cycle the block either returns a hit and the 24-bit physical address, or raises a miss that the pipeline treats as an exception. Every stored translation carries a dirty flag. A write that hits sets that flag, so software can learn which pages were modified.

Software loads translations through a refill port. A refill takes the lowest-numbered empty slot. When no slot is empty, a round-robin pointer selects the slot to overwrite. If the overwritten translation was dirty, the block emits a one-cycle report that carries its virtual page number, so the page table can record the change. An invalidate port removes a translation by virtual page number, for example when the page leaves physical memory.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no translation is valid: every lookup misses, and `evict_dirty_o` stays 0 until a refill replaces a dirty translation.
- R2: When `lk_valid_i` is 1 and a valid slot holds virtual page `lk_vaddr_i[31:10]`, `lk_hit_o` is 1, `lk_miss_o` is 0 and `lk_paddr_o` is {stored 14-bit physical page, `lk_vaddr_i[9:0]`}, all combinationally in the same cycle.
- R3: When `lk_valid_i` is 1 and no valid slot matches, `lk_miss_o` is 1, `lk_hit_o` is 0 and `lk_paddr_o` is 0. When `lk_valid_i` is 0, both `lk_hit_o` and `lk_miss_o` are 0 and `lk_paddr_o` is 0.
- R4: A lookup with `lk_write_i`=1 that hits sets that slot's dirty flag at the clock edge. A read hit leaves the flag unchanged, so a later replacement of a slot that only saw reads produces no report.
- R5: A refill (`fill_valid_i`=1) stores `fill_vpn_i` and `fill_ppn_i`, marks the slot valid and clean, and takes effect at the clock edge. A lookup in the same cycle as the refill still sees the contents from before the edge.
- R6: When at least one slot is invalid, a refill writes the lowest-numbered invalid slot. It produces no eviction report and does not move the round-robin pointer.
- R7: When all slots are valid, a refill overwrites the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, modulo the slot count, on each such replacement only.
- R8: In the cycle after a refill that replaced a dirty slot, `evict_dirty_o` is 1 for exactly that cycle and `evict_vpn_o` holds the replaced virtual page number. Replacing a clean slot produces no pulse.
- R9: An invalidate (`inv_valid_i`=1) clears the valid flag of the slot matching `inv_vpn_i`. Later lookups of that page miss, the slot becomes the next refill target, and invalidating a dirty slot produces no eviction report.
- R10: When an invalidate and a refill arrive in the same cycle, the refill target is chosen from the valid flags as they stood before the edge. The invalidate clears its matching slot, and the refilled slot ends valid.
- R11: A write hit in the same cycle as a refill that replaces that same slot counts as dirty: the eviction report is produced, and the slot ends clean with the new translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_write_i | input | 1 | Lookup is a write access |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No valid translation (exception) |
| lk_paddr_o | output | 24 | Physical address on hit, 0 otherwise |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 22 | Virtual page number to store |
| fill_ppn_i | input | 14 | Physical page number to store |
| inv_valid_i | input | 1 | Invalidate request |
| inv_vpn_i | input | 22 | Virtual page number to remove |
| evict_dirty_o | output | 1 | One-cycle pulse: a dirty translation was replaced |
| evict_vpn_o | output | 22 | Virtual page number of the replaced dirty translation |

## Verification
The assertions assume that software never refills a virtual page that is already held in a valid slot, so at most one slot matches any page number. The stimulus keeps to this assumption: every refill uses a page number that is not currently resident, and a page is refilled again only after its slot has been replaced or invalidated. Same-cycle interactions are driven on purpose: a lookup during a refill, an invalidate during a refill, and a write hit on the slot being replaced. A bench model computes the expected victim order and dirty state for each of these cases.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_ENTRIES = 8;
  localparam int unsigned TLB_VA_W    = 32;
  localparam int unsigned TLB_PA_W    = 24;
  localparam int unsigned TLB_OFF_W   = 10;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 22
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] tag_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic             replace_o
);
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic [IDX_W-1:0] rr_q;

  tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) u_free_enc (
    .req_i (~valid_i),
    .idx_o (free_idx),
    .any_o (free_any)
  );

  assign tgt_idx_o = free_any ? free_idx : rr_q;
  assign replace_o = ~free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_i && replace_o) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !replace_o) |=> $stable(rr_q)); // R6
  AST_REPL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && replace_o) |-> (&valid_i)); // R7
  AST_RR_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && replace_o) |=> !$stable(rr_q) || (N == 1)); // R7
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int unsigned NUM_ENTRIES = tlb_pkg::TLB_ENTRIES,
  parameter int unsigned VA_W        = tlb_pkg::TLB_VA_W,
  parameter int unsigned PA_W        = tlb_pkg::TLB_PA_W,
  parameter int unsigned OFF_W       = tlb_pkg::TLB_OFF_W,
  localparam int unsigned VPN_W      = VA_W - OFF_W,
  localparam int unsigned PPN_W      = PA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic             lk_write_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             inv_valid_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  output logic             evict_dirty_o,
  output logic [VPN_W-1:0] evict_vpn_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0]            valid_q, dirty_q;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [NUM_ENTRIES-1:0][PPN_W-1:0] ppn_q;

  logic [VPN_W-1:0]       lk_vpn;
  logic [NUM_ENTRIES-1:0] lk_match, inv_match, wr_set;
  logic [IDX_W-1:0]       hit_idx, fill_idx;
  logic                   hit_any, replace;
  logic                   victim_dirty;

  logic             evict_q;
  logic [VPN_W-1:0] evict_vpn_q;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFF_W];

  tlb_cam #(.N(NUM_ENTRIES), .W(VPN_W)) u_lk_cam (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .key_i   (lk_vpn),
    .match_o (lk_match)
  );

  tlb_cam #(.N(NUM_ENTRIES), .W(VPN_W)) u_inv_cam (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .key_i   (inv_vpn_i),
    .match_o (inv_match)
  );

  tlb_prio_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
    .req_i (lk_match),
    .idx_o (hit_idx),
    .any_o (hit_any)
  );

  tlb_repl #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_repl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_q),
    .fill_i    (fill_valid_i),
    .tgt_idx_o (fill_idx),
    .replace_o (replace)
  );

  assign lk_hit_o   = lk_valid_i && hit_any;
  assign lk_miss_o  = lk_valid_i && !hit_any;
  assign lk_paddr_o = lk_hit_o ? {ppn_q[hit_idx], lk_vaddr_i[OFF_W-1:0]} : '0;

  assign wr_set = (lk_hit_o && lk_write_i) ? lk_match : '0;

  // a write hit landing on the victim this cycle still counts as dirty
  assign victim_dirty = dirty_q[fill_idx] || wr_set[fill_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (fill_valid_i && fill_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
          vpn_q[i]   <= fill_vpn_i;
          ppn_q[i]   <= fill_ppn_i;
        end else begin
          if (inv_valid_i && inv_match[i]) valid_q[i] <= 1'b0;
          if (wr_set[i]) dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evict_q     <= 1'b0;
      evict_vpn_q <= '0;
    end else begin
      evict_q <= fill_valid_i && replace && victim_dirty;
      if (fill_valid_i && replace && victim_dirty) evict_vpn_q <= vpn_q[fill_idx];
    end
  end

  assign evict_dirty_o = evict_q;
  assign evict_vpn_o   = evict_vpn_q;

  AST_LK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R2
  AST_MISS_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0)); // R3
  AST_HIT_XOR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> (lk_hit_o != lk_miss_o)); // R3
  AST_WR_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_write_i && !fill_valid_i) |=> dirty_q[$past(hit_idx)]); // R4
  AST_FILL_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)])); // R5
  AST_EVICT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_dirty_o |-> $past(fill_valid_i)); // R8
  AST_INV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && !fill_valid_i) |=> ((valid_q & $past(inv_match)) == '0)); // R9
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0, lk_write_i = 1'b0;
  logic [31:0] lk_vaddr_i = '0;
  logic        lk_hit_o, lk_miss_o;
  logic [23:0] lk_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [21:0] fill_vpn_i = '0;
  logic [13:0] fill_ppn_i = '0;
  logic        inv_valid_i = 1'b0;
  logic [21:0] inv_vpn_i = '0;
  logic        evict_dirty_o;
  logic [21:0] evict_vpn_o;

  always #2 clk = ~clk;

  tlb_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_write_i(lk_write_i),
    .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_paddr_o(lk_paddr_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .inv_valid_i(inv_valid_i), .inv_vpn_i(inv_vpn_i),
    .evict_dirty_o(evict_dirty_o), .evict_vpn_o(evict_vpn_o)
  );

  typedef struct {
    string       tag;
    logic        hit;
    logic        miss;
    logic [23:0] pa;
    logic        ev;
    logic [21:0] evpn;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit          m_v[N];
  bit          m_d[N];
  logic [21:0] m_vpn[N];
  logic [13:0] m_ppn[N];
  int          m_rr = 0;
  bit          pend_ev = 1'b0;
  logic [21:0] pend_vpn = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit lv, logic [31:0] va, bit wr,
                      bit fv, logic [21:0] fvpn, logic [13:0] fppn,
                      bit iv, logic [21:0] ivpn);
    exp_t e;
    int hi, t;
    bit rep, nev;
    logic [21:0] nvpn;
    @(negedge clk);
    lk_valid_i = lv; lk_vaddr_i = va; lk_write_i = wr;
    fill_valid_i = fv; fill_vpn_i = fvpn; fill_ppn_i = fppn;
    inv_valid_i = iv; inv_vpn_i = ivpn;
    hi = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == va[31:10]) hi = i;
    e.tag  = tag;
    e.hit  = lv && (hi >= 0);
    e.miss = lv && (hi < 0);
    e.pa   = (lv && hi >= 0) ? {m_ppn[hi], va[9:0]} : 24'h0;
    e.ev   = pend_ev;
    e.evpn = pend_vpn;
    q.push_back(e);
    t = -1;
    for (int i = 0; i < N; i++) if (!m_v[i] && t < 0) t = i;
    rep = (t < 0);
    if (rep) t = m_rr;
    nev  = fv && rep && (m_d[t] || (lv && wr && hi == t));
    nvpn = m_vpn[t];
    if (lv && wr && hi >= 0) m_d[hi] = 1'b1;
    if (iv) for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == ivpn) m_v[i] = 1'b0;
    if (fv) begin
      m_v[t] = 1'b1; m_d[t] = 1'b0; m_vpn[t] = fvpn; m_ppn[t] = fppn;
      if (rep) m_rr = (m_rr + 1) % N;
    end
    pend_ev = nev;
    if (nev) pend_vpn = nvpn;
  endtask

  task automatic look(string tag, logic [21:0] vpn, logic [9:0] off, bit wr);
    step(tag, 1'b1, {vpn, off}, wr, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic fill(string tag, logic [21:0] vpn, logic [13:0] ppn);
    step(tag, 1'b0, '0, 1'b0, 1'b1, vpn, ppn, 1'b0, '0);
  endtask

  task automatic inval(string tag, logic [21:0] vpn);
    step(tag, 1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, vpn);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "hit",  {31'h0, lk_hit_o},  {31'h0, e.hit});
        chk(e.tag, "miss", {31'h0, lk_miss_o}, {31'h0, e.miss});
        chk(e.tag, "paddr", {8'h0, lk_paddr_o}, {8'h0, e.pa});
        chk(e.tag, "evict", {31'h0, evict_dirty_o}, {31'h0, e.ev});
        if (e.ev) chk(e.tag, "evict_vpn", {10'h0, evict_vpn_o}, {10'h0, e.evpn});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_d[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset hit", {31'h0, lk_hit_o}, 32'h0);
    chk("R1", "reset evict", {31'h0, evict_dirty_o}, 32'h0);
    rst_ni = 1'b1;
    idle("R1");
    look("R1", 22'h100, 10'h3, 1'b0);
    // fills into empty slots, lookup of the same page in the fill cycle misses
    for (int i = 0; i < N; i++)
      step("R5", 1'b1, {22'h100 + 22'(i), 10'h7}, 1'b0, 1'b1, 22'h100 + 22'(i), 14'h20 + 14'(i), 1'b0, '0);
    for (int i = 0; i < N; i++) look("R2", 22'h100 + 22'(i), 10'(i * 37 + 5), 1'b0);
    look("R2", 22'h107, 10'h3ff, 1'b0);
    look("R4", 22'h102, 10'h11, 1'b1);
    look("R4", 22'h105, 10'h22, 1'b1);
    look("R4", 22'h101, 10'h33, 1'b0);
    look("R4", 22'h101, 10'h34, 1'b0);
    step("R3", 1'b0, {22'h103, 10'h1}, 1'b0, 1'b0, '0, '0, 1'b0, '0);
    look("R3", 22'h3abcd, 10'h0, 1'b0);
    // full: round-robin replacement 0..5, dirty slots 2 and 5 reported
    for (int i = 0; i < 6; i++) fill("R8", 22'h200 + 22'(i), 14'h40 + 14'(i));
    idle("R8");
    idle("R8");
    look("R3", 22'h102, 10'h0, 1'b0);
    look("R7", 22'h202, 10'h55, 1'b0);
    look("R7", 22'h106, 10'h56, 1'b0);
    // invalidate frees slot 3, next fill reuses it
    inval("R9", 22'h203);
    look("R9", 22'h203, 10'h1, 1'b0);
    fill("R6", 22'h300, 14'h60);
    look("R6", 22'h300, 10'h2, 1'b0);
    fill("R7", 22'h301, 14'h61);
    look("R7", 22'h106, 10'h0, 1'b0);
    // same-cycle invalidate and refill
    step("R10", 1'b0, '0, 1'b0, 1'b1, 22'h302, 14'h62, 1'b1, 22'h204);
    look("R10", 22'h204, 10'h0, 1'b0);
    look("R10", 22'h302, 10'h9, 1'b0);
    fill("R10", 22'h303, 14'h63);
    look("R10", 22'h303, 10'ha, 1'b0);
    look("R10", 22'h107, 10'h0, 1'b0);
    // write hit on the victim in the refill cycle
    step("R11", 1'b1, {22'h200, 10'h5}, 1'b1, 1'b1, 22'h304, 14'h64, 1'b0, '0);
    look("R11", 22'h304, 10'h6, 1'b0);
    look("R11", 22'h200, 10'h6, 1'b0);
    // read-only slot replaced: no report
    fill("R4", 22'h305, 14'h65);
    idle("R4");
    // dirty slot invalidated: no report, slot reused
    look("R9", 22'h300, 10'h7, 1'b1);
    inval("R9", 22'h300);
    idle("R9");
    fill("R9", 22'h306, 14'h66);
    look("R9", 22'h306, 10'h8, 1'b0);
    look("R9", 22'h300, 10'h8, 1'b0);
    idle("R8");
    idle("R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule